// File: doc/BRIEF.md
# Multicast Hash Filter

This block sits on the receive side of an Ethernet MAC. It looks at the destination address of an incoming frame and decides whether the frame is kept. The six address octets arrive one per accepted cycle, and a start strobe marks the first one. A CRC is accumulated over the octets as they arrive. Once the sixth octet is in, the block forms a single keep-or-drop decision and raises a one-cycle done strobe.

Multicast destinations are checked against a 128-bit hash table. Seven bits of the CRC select one table bit. Unicast destinations are compared exactly against two programmable station addresses. The broadcast address always passes. Each filter has its own enable. When a filter is disabled, every frame of its class passes.

Software programs the hash table and the station addresses through a simple 32-bit write port. A power-down lock input freezes all of these registers, so writes made while the lock is set are lost.

Top module: `mhash_filter`

## Requirements
- R1: The CRC covers exactly the six address octets, in arrival order. It uses polynomial 0x04C11DB7 and starts from all ones. Each octet is shifted in least significant bit first, with feedback taken from CRC bit 31. There is no final inversion. The table index is CRC bits 29 down to 23, with bit 29 as the index MSB.
- R2: Register addresses 0, 1, 2 and 3 hold table indexes 0–31, 32–63, 64–95 and 96–127 respectively. Within the selected word, the bit position is the index minus 32 times the word number.
- R3: An address whose first octet has bit 0 set, and which is not broadcast, is multicast. With multiFiltEn high, a multicast address is accepted only when its table bit is 1. With multiFiltEn low, every multicast address is accepted.
- R4: The all-ones broadcast address is accepted whatever the enables and table contents are.
- R5: With uniFiltEn high, a unicast address is accepted only when it equals station address A or station address B. With uniFiltEn low, every unicast address is accepted.
- R6: The station addresses are laid out across three registers, with octet 1 the first octet on the wire:
  - Register 6 holds the leading octets: bits 31:24 are A octet 1, 23:16 are A octet 2, 15:8 are B octet 1 and 7:0 are B octet 2.
  - Register 4 holds A octets 3 to 6 and register 5 holds B octets 3 to 6, each with octet 3 in bits 31:24 and octet 6 in bits 7:0.
- R7: While powerLock is high, writes to registers 0 to 6 have no effect.
- R8: done is high for exactly one cycle, namely the cycle after the sixth octet is taken. accept is valid in that cycle and holds its value until the next decision.
- R9: Octets are taken only on cycles with byteValid high, and idle cycles between octets are allowed. frameStart with byteValid discards any partial address and begins a new one. byteValid without a frame in progress is ignored.
- R10: After reset, done and accept are 0 and all table and station registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrByte | input | 8 | Destination address octet |
| byteValid | input | 1 | addrByte carries an octet this cycle |
| frameStart | input | 1 | Marks the first octet of an address |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select (0–3 table, 4–6 station) |
| regWrData | input | 32 | Register write data |
| uniFiltEn | input | 1 | Enables exact unicast filtering |
| multiFiltEn | input | 1 | Enables multicast hash filtering |
| powerLock | input | 1 | Blocks all register writes |
| accept | output | 1 | Decision: 1 keeps the frame |
| done | output | 1 | One-cycle strobe when accept is updated |

## Verification
A wrong CRC bit or a mis-mapped table word never shows as a timing error. It shows as the wrong accept value at the very next done strobe of an address that hashes to the affected bit. For this reason the bench places a single set bit, and a single cleared bit, in each of the four table words. A wrong octet count shows as done arriving a cycle early or late, or not at all, so every frame checks done at the expected cycle and again one cycle later. A lock that leaks is only visible on a later frame, so each locked write is followed by frames whose expected decision depends on the old register contents.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int OCTETS     = 6;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = OCTETS * BYTE_W;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int HASH_BITS  = 128;
  localparam int WORD_W     = 32;
  localparam int HASH_WORDS = HASH_BITS / WORD_W;
  localparam int IDX_W      = $clog2(HASH_BITS);
  localparam int IDX_LSB    = 23;
  localparam int SEL_W      = $clog2(HASH_WORDS);
  localparam int BIT_W      = $clog2(WORD_W);
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] REG_STA_A_LO = 3'd4;
  localparam logic [REG_ADDR_W-1:0] REG_STA_B_LO = 3'd5;
  localparam logic [REG_ADDR_W-1:0] REG_STA_HI   = 3'd6;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeByte;
    logic firstByte;
    logic lastByte;
  } mhfStrobe_t;

  // One octet into the running CRC, low bit first
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [BYTE_W-1:0] octet);
    logic [CRC_W-1:0] r;
    r = crcIn;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[CRC_W-1] ^ octet[i]) r = (r << 1) ^ CRC_POLY;
      else                       r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       frameStart,
  output mhfStrobe_t strobe
);

  localparam int CNT_W = $clog2(OCTETS + 1);

  logic [CNT_W-1:0] octetCnt;
  logic             busy;

  always_comb begin
    strobe = '0;
    if (byteValid) begin
      if (frameStart) begin
        strobe.takeByte  = 1'b1;
        strobe.firstByte = 1'b1;
        strobe.lastByte  = (OCTETS == 1);
      end else if (busy) begin
        strobe.takeByte  = 1'b1;
        strobe.lastByte  = (octetCnt == CNT_W'(OCTETS - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      octetCnt <= '0;
    end else if (strobe.takeByte) begin
      if (strobe.lastByte) begin
        busy     <= 1'b0;
        octetCnt <= '0;
      end else begin
        busy     <= 1'b1;
        octetCnt <= strobe.firstByte ? CNT_W'(1) : octetCnt + 1'b1;
      end
    end
  end

  // R9: counter never passes the last octet slot
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    octetCnt <= CNT_W'(OCTETS - 1));

  // R9: idle cycles inside a frame leave the position unchanged
  assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !byteValid) |=> $stable(octetCnt));

endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  mhfStrobe_t            strobe,
  input  logic [BYTE_W-1:0]     addrByte,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  input  logic                  uniFiltEn,
  input  logic                  multiFiltEn,
  input  logic                  powerLock,
  output logic                  accept,
  output logic                  done
);

  localparam int HEAD_W = ADDR_W - BYTE_W;

  logic [WORD_W-1:0] hashWord [HASH_WORDS];
  logic [WORD_W-1:0] staALo, staBLo, staHi;
  logic [CRC_W-1:0]  crcReg, crcSeed, crcNow;
  logic [HEAD_W-1:0] headReg;
  logic [ADDR_W-1:0] fullAddr, staA, staB;
  logic [IDX_W-1:0]  hashIdx;
  logic [SEL_W-1:0]  wordSel;
  logic [BIT_W-1:0]  bitSel;
  logic              hashHit, isBcast, isMcast, uniHit, decision;
  logic              wrOk;

  assign wrOk = regWrEn && !powerLock;

  // Hash table words, one per index range
  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rstN)
        hashWord[w] <= '0;
      else if (wrOk && regAddr == REG_ADDR_W'(w))
        hashWord[w] <= regWrData;
    end

    // R7: a locked cycle cannot alter the table
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      powerLock |=> $stable(hashWord[w]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staALo <= '0;
      staBLo <= '0;
      staHi  <= '0;
    end else if (wrOk) begin
      case (regAddr)
        REG_STA_A_LO: staALo <= regWrData;
        REG_STA_B_LO: staBLo <= regWrData;
        REG_STA_HI:   staHi  <= regWrData;
        default: ;
      endcase
    end
  end

  assert_lock_sta_R7: assert property (@(posedge clk) disable iff (!rstN)
    powerLock |=> $stable({staALo, staBLo, staHi}));

  // Running CRC and octet capture
  assign crcSeed  = strobe.firstByte ? '1 : crcReg;
  assign crcNow   = crcByte(crcSeed, addrByte);
  assign fullAddr = {headReg, addrByte};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= '1;
      headReg <= '0;
    end else if (strobe.takeByte) begin
      crcReg  <= crcNow;
      headReg <= strobe.firstByte ? HEAD_W'(addrByte)
                                  : {headReg[HEAD_W-BYTE_W-1:0], addrByte};
    end
  end

  // Table lookup
  assign hashIdx = crcNow[IDX_LSB +: IDX_W];
  assign wordSel = hashIdx[IDX_W-1 -: SEL_W];
  assign bitSel  = hashIdx[BIT_W-1:0];
  assign hashHit = hashWord[wordSel][bitSel];

  // Station match
  assign staA   = {staHi[WORD_W-1 -: 2*BYTE_W], staALo};
  assign staB   = {staHi[2*BYTE_W-1:0], staBLo};
  assign uniHit = (fullAddr == staA) || (fullAddr == staB);

  assign isBcast = &fullAddr;
  assign isMcast = fullAddr[ADDR_W - BYTE_W];

  always_comb begin
    if (isBcast)      decision = 1'b1;
    else if (isMcast) decision = !multiFiltEn || hashHit;
    else              decision = !uniFiltEn || uniHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accept <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= strobe.lastByte;
      if (strobe.lastByte) accept <= decision;
    end
  end

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastByte |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_accept_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.lastByte |=> $stable(accept));

  assert_bcast_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lastByte && isBcast) |=> accept);

endmodule

// File: rtl/mhash_filter.sv
module mhash_filter
  import mhf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BYTE_W-1:0]     addrByte,
  input  logic                  byteValid,
  input  logic                  frameStart,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  input  logic                  uniFiltEn,
  input  logic                  multiFiltEn,
  input  logic                  powerLock,
  output logic                  accept,
  output logic                  done
);

  mhfStrobe_t strobe;

  mhf_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .frameStart (frameStart),
    .strobe     (strobe)
  );

  mhf_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addrByte    (addrByte),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .uniFiltEn   (uniFiltEn),
    .multiFiltEn (multiFiltEn),
    .powerLock   (powerLock),
    .accept      (accept),
    .done        (done)
  );

endmodule

// File: tb/test_mhash_filter.sv
module test_mhash_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addrByte = '0;
  logic        byteValid = 1'b0, frameStart = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        uniFiltEn = 1'b0, multiFiltEn = 1'b0, powerLock = 1'b0;
  logic        accept, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [127:0] tbHash = '0;
  logic [31:0]  tbALo = '0, tbBLo = '0, tbHi = '0;

  always #2 clk = ~clk;

  mhash_filter i_mhash_filter (
    .clk(clk), .rstN(rstN), .addrByte(addrByte), .byteValid(byteValid),
    .frameStart(frameStart), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .uniFiltEn(uniFiltEn), .multiFiltEn(multiFiltEn),
    .powerLock(powerLock), .accept(accept), .done(done)
  );

  localparam logic [47:0] ADDR_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] ADDR_B = 48'h0A_BB_CC_DD_EE_F0;
  localparam logic [47:0] MC_ON  = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MC_OFF = 48'h01_00_5E_7F_12_34;

  // {address, uniFiltEn, multiFiltEn}
  localparam int NVEC = 10;
  localparam logic [49:0] VEC [NVEC] = '{
    {ADDR_A, 1'b1, 1'b1},
    {ADDR_B, 1'b1, 1'b1},
    {48'h02_11_22_33_44_56, 1'b1, 1'b1},
    {48'h02_11_22_33_44_56, 1'b0, 1'b1},
    {48'h0A_BB_CC_33_44_55, 1'b1, 1'b1},
    {48'hFF_FF_FF_FF_FF_FF, 1'b1, 1'b1},
    {MC_ON,  1'b1, 1'b1},
    {MC_OFF, 1'b1, 1'b1},
    {MC_OFF, 1'b1, 1'b0},
    {48'h03_11_22_33_44_55, 1'b1, 1'b1}
  };

  function automatic logic [6:0] refIdx(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++)
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[47 - 8*k - 7 + j];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return c[29:23];
  endfunction

  function automatic logic refAccept(input logic [47:0] a, input logic ue, input logic me);
    if (&a) return 1'b1;
    if (a[40]) return !me || tbHash[refIdx(a)];
    return !ue || a == {tbHi[31:16], tbALo} || a == {tbHi[15:0], tbBLo};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    if (!powerLock) begin
      if (a < 3'd4) tbHash[32*a +: 32] = d;
      else if (a == 3'd4) tbALo = d;
      else if (a == 3'd5) tbBLo = d;
      else if (a == 3'd6) tbHi = d;
    end
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // Sends six octets; gap idle cycles between octets; checks done timing and accept
  task automatic sendAddr(input logic [47:0] a, input int gap, input string tag,
                          input logic expAcc);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); addrByte = a[47 - 8*i -: 8];
      if (i < 5)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          byteValid = 1'b0; frameStart = 1'b0;
          check("R8 no early done", {31'b0, done}, 32'd0);
        end
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0;
    check("R8 done after sixth octet", {31'b0, done}, 32'd1);
    check(tag, {31'b0, accept}, {31'b0, expAcc});
    @(negedge clk);
    check("R8 done single cycle", {31'b0, done}, 32'd0);
    check("R8 accept held", {31'b0, accept}, {31'b0, expAcc});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [47:0] addr;
    logic [6:0] idx;
    logic found;
    string tag;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10 done after reset", {31'b0, done}, 32'd0);
    check("R10 accept after reset", {31'b0, accept}, 32'd0);
    uniFiltEn = 1'b1; multiFiltEn = 1'b1;
    sendAddr(MC_ON, 0, "R10 table cleared", 1'b0);
    sendAddr(ADDR_A, 0, "R10 stations cleared", 1'b0);

    // R6: station registers
    writeReg(3'd4, 32'h22_33_44_55);
    writeReg(3'd5, 32'hCC_DD_EE_F0);
    writeReg(3'd6, 32'h02_11_0A_BB);
    idx = refIdx(MC_ON);
    writeReg({1'b0, idx[6:5]}, 32'h1 << idx[4:0]);

    // Vector walk: R3, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      addr = VEC[v][49:2];
      uniFiltEn = VEC[v][1]; multiFiltEn = VEC[v][0];
      if (&addr) tag = "R4 broadcast";
      else if (addr[40]) tag = "R3 multicast";
      else tag = "R5 R6 unicast";
      sendAddr(addr, 0, tag, refAccept(addr, VEC[v][1], VEC[v][0]));
    end

    // R1 R2: one address per table word
    uniFiltEn = 1'b1; multiFiltEn = 1'b1;
    for (int w = 0; w < 4; w++) begin
      found = 1'b0;
      addr = '0;
      for (int k = 0; k < 256 && !found; k++) begin
        addr = {40'h01_00_5E_80_00, 8'(k)};
        if (refIdx(addr) >> 5 == 7'(w)) found = 1'b1;
      end
      check("R2 index search", {31'b0, found}, 32'd1);
      idx = refIdx(addr);
      for (int u = 0; u < 4; u++)
        writeReg(3'(u), (u == w) ? ~(32'h1 << idx[4:0]) : 32'hFFFF_FFFF);
      sendAddr(addr, 0, "R1 R2 bit cleared", 1'b0);
      for (int u = 0; u < 4; u++)
        writeReg(3'(u), (u == w) ? (32'h1 << idx[4:0]) : 32'h0);
      sendAddr(addr, 0, "R1 R2 bit set", 1'b1);
    end

    // R7: locked writes are lost
    for (int u = 0; u < 4; u++) writeReg(3'(u), 32'h0);
    powerLock = 1'b1;
    for (int u = 0; u < 4; u++) writeReg(3'(u), 32'hFFFF_FFFF);
    writeReg(3'd4, 32'h0);
    writeReg(3'd6, 32'h0);
    powerLock = 1'b0;
    sendAddr(MC_OFF, 0, "R7 table frozen", 1'b0);
    sendAddr(MC_ON, 0, "R7 table frozen", 1'b0);
    sendAddr(ADDR_A, 0, "R7 station frozen", 1'b1);

    // R9: idle gaps between octets
    sendAddr(ADDR_B, 2, "R9 gapped octets", 1'b1);

    // R9: bytes without a frame in progress are ignored
    found = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (done) found = 1'b1;
      byteValid = 1'b1; frameStart = 1'b0; addrByte = 8'h55;
    end
    @(negedge clk);
    byteValid = 1'b0;
    if (done) found = 1'b1;
    @(negedge clk);
    if (done) found = 1'b1;
    check("R9 stray bytes ignored", {31'b0, found}, 32'd0);

    // R9: restart discards a partial address
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); addrByte = 8'h99;
    end
    sendAddr(ADDR_A, 0, "R9 restart", 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule